// File: doc/BRIEF.md
# Stack-Linked 16-bit Microcontroller Core

A compact 16-bit processor core that runs a small variable-length instruction set out of its own byte-addressed memory. It keeps a program counter, a downward-growing stack pointer and four 16-bit general registers. A multi-cycle state machine fetches the opcode byte, then each operand byte in turn, and then performs a single execute step. That step updates the registers, the stack or the program counter.

The instruction set has seven opcodes: load immediate, push, pop, call, return, a word load at an offset above the stack pointer, and halt. Call and return pass the return address through the stack, so nested subroutines and stack-passed parameters work. An unknown opcode stops the core and sets a sticky flag.

For preloading, the core is held with `run_i` low and bytes are written through a dedicated load port. A separate peek port reads memory bytes and a selector reads the registers, so results can be observed without disturbing execution.

Top module: `stk_core`

## Requirements
- R1: After reset, PC is 0x0000, SP is 0x8000, r0 to r3 are zero, and both `halted_o` and `illegal_o` are low.
- R2: Opcode 0x01 is a 3-byte instruction. Byte 2 selects register r0 to r3 in bits [1:0], and byte 3 is loaded into that register zero-extended. Execution continues at PC+3.
- R3: Opcode 0x02 is a 2-byte instruction. It lowers SP by 2 and then stores the named register at the new SP as a little-endian word, low byte first.
- R4: Opcode 0x04 is a 2-byte instruction. It loads the little-endian word at SP into the named register and then raises SP by 2.
- R5: Opcode 0x03 is a 3-byte instruction. Its target is bytes 2 (low) and 3 (high). It pushes the address of the next instruction exactly as a push does, then jumps to the target.
- R6: Opcode 0x07 is a 1-byte instruction. It loads PC from the word at SP and then raises SP by 2.
- R7: Opcode 0x06 is a 3-byte instruction. Byte 2 names the register and byte 3 is an unsigned offset. It loads the word at SP plus that offset, and SP is left unchanged.
- R8: Opcode 0x05 is a 1-byte instruction. It stops the core with PC held at the address of the halt opcode, and `halted_o` stays high until reset.
- R9: Any opcode outside 0x01 to 0x07 stops the core like a halt, at its own address. It also sets `illegal_o`, which stays high until reset.
- R10: While `run_i` is low, PC, SP and the registers hold their values. Byte writes through the load port still reach memory.
- R11: Memory decodes only the low MEM_AW bits of an address, with a default of 9 bits (512 bytes). Stack address 0x7FFE and address 0x01FE therefore name the same byte.
- R12: SP only ever changes in steps of exactly 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Execution enable |
| ld_we_i | input | 1 | Load-port byte write strobe |
| ld_addr_i | input | 16 | Load-port byte address |
| ld_data_i | input | 8 | Load-port byte data |
| peek_addr_i | input | 16 | Peek-port byte address |
| peek_data_o | output | 8 | Memory byte at peek address |
| reg_sel_i | input | 2 | Register readback select |
| reg_data_o | output | 16 | Selected register value |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| halted_o | output | 1 | Core stopped |
| illegal_o | output | 1 | Sticky undefined-opcode flag |

## Verification
Random straight-line programs mix immediate loads, pushes, pops and offset loads at varying stack depths. Comparing the resulting registers, SP and stack bytes against a bench instruction model exposes operand-order, byte-order and SP-sequencing errors. A directed call/return program with a stack-passed parameter separates return-address and link handling from plain push/pop. Further directed cases cover an undefined opcode, a long dwell after halt, a held `run_i`, and a peek at an aliased stack address; these isolate the stopping, hold and address-decode behaviours.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam logic [7:0] OP_LDI  = 8'h01;
  localparam logic [7:0] OP_PUSH = 8'h02;
  localparam logic [7:0] OP_CALL = 8'h03;
  localparam logic [7:0] OP_POP  = 8'h04;
  localparam logic [7:0] OP_HALT = 8'h05;
  localparam logic [7:0] OP_LDSP = 8'h06;
  localparam logic [7:0] OP_RET  = 8'h07;

  typedef enum logic [2:0] {S_OP, S_B1, S_B2, S_EXE, S_STOP} state_t;

  function automatic logic op_legal(input logic [7:0] op);
    return (op >= OP_LDI) && (op <= OP_RET);
  endfunction

  function automatic logic op_three(input logic [7:0] op);
    return (op == OP_LDI) || (op == OP_CALL) || (op == OP_LDSP);
  endfunction
endpackage

// File: rtl/stk_mem.sv
module stk_mem #(
  parameter int W  = 16,
  parameter int AW = 9
) (
  input  logic         clk_i,
  input  logic         we_lo_i,
  input  logic         we_hi_i,
  input  logic [W-1:0] wa_i,
  input  logic [15:0]  wd_i,
  input  logic [W-1:0] ra_i,
  output logic [15:0]  rd_o,
  input  logic [W-1:0] pa_i,
  output logic [7:0]   pd_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];
  logic [AW-1:0] wa_lo, wa_hi, ra_lo, ra_hi, pa;

  assign wa_lo = wa_i[AW-1:0];
  assign wa_hi = wa_lo + 1'b1;
  assign ra_lo = ra_i[AW-1:0];
  assign ra_hi = ra_lo + 1'b1;
  assign pa    = pa_i[AW-1:0];

  always_ff @(posedge clk_i) begin
    if (we_lo_i) mem_q[wa_lo] <= wd_i[7:0];
    if (we_hi_i) mem_q[wa_hi] <= wd_i[15:8];
  end

  assign rd_o = {mem_q[ra_hi], mem_q[ra_lo]};
  assign pd_o = mem_q[pa];
endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
  parameter int NREG = 4,
  parameter int W    = 16,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] wsel_i,
  input  logic [W-1:0]  wd_i,
  input  logic [SW-1:0] rsel_a_i,
  output logic [W-1:0]  rd_a_o,
  input  logic [SW-1:0] rsel_b_i,
  output logic [W-1:0]  rd_b_o
);
  logic [W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (we_i && wsel_i == SW'(g)) regs_q[g] <= wd_i;
    end
  end

  assign rd_a_o = regs_q[rsel_a_i];
  assign rd_b_o = regs_q[rsel_b_i];
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int          W      = 16,
  parameter int          SW     = 2,
  parameter logic [15:0] SP_RST = 16'h8000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [15:0]   rdata_i,
  output logic [W-1:0]  raddr_o,
  input  logic [W-1:0]  reg_rd_i,
  output logic [SW-1:0] reg_sel_o,
  output logic          reg_we_o,
  output logic [W-1:0]  reg_wd_o,
  output logic          mem_we_o,
  output logic [W-1:0]  mem_wa_o,
  output logic [15:0]   mem_wd_o,
  output logic [W-1:0]  pc_o,
  output logic [W-1:0]  sp_o,
  output logic          halted_o,
  output logic          illegal_o
);
  state_t       state_q;
  logic [7:0]   op_q, b1_q, b2_q;
  logic [W-1:0] pc_q, sp_q;
  logic         ill_q;
  logic         exe;

  assign exe = run_i && (state_q == S_EXE);

  always_comb begin
    raddr_o = pc_q;
    if (state_q == S_EXE)
      raddr_o = (op_q == OP_LDSP) ? sp_q + W'(b2_q) : sp_q;
  end

  assign reg_sel_o = b1_q[SW-1:0];
  assign reg_we_o  = exe && (op_q == OP_LDI || op_q == OP_POP || op_q == OP_LDSP);
  assign reg_wd_o  = (op_q == OP_LDI) ? W'(b2_q) : rdata_i[W-1:0];
  assign mem_we_o  = exe && (op_q == OP_PUSH || op_q == OP_CALL);
  assign mem_wa_o  = sp_q - W'(2);
  assign mem_wd_o  = (op_q == OP_CALL) ? 16'(pc_q) : 16'(reg_rd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_OP;
      op_q    <= '0;
      b1_q    <= '0;
      b2_q    <= '0;
      pc_q    <= '0;
      sp_q    <= W'(SP_RST);
      ill_q   <= 1'b0;
    end else if (run_i) begin
      case (state_q)
        S_OP: begin
          op_q <= rdata_i[7:0];
          if (!op_legal(rdata_i[7:0])) begin
            ill_q   <= 1'b1;
            state_q <= S_STOP;
          end else if (rdata_i[7:0] == OP_HALT) begin
            state_q <= S_STOP;
          end else if (rdata_i[7:0] == OP_RET) begin
            state_q <= S_EXE;
          end else begin
            pc_q    <= pc_q + 1'b1;
            state_q <= S_B1;
          end
        end
        S_B1: begin
          b1_q    <= rdata_i[7:0];
          pc_q    <= pc_q + 1'b1;
          state_q <= op_three(op_q) ? S_B2 : S_EXE;
        end
        S_B2: begin
          b2_q    <= rdata_i[7:0];
          pc_q    <= pc_q + 1'b1;
          state_q <= S_EXE;
        end
        S_EXE: begin
          case (op_q)
            OP_PUSH: sp_q <= sp_q - W'(2);
            OP_CALL: begin
              sp_q <= sp_q - W'(2);
              pc_q <= W'({b2_q, b1_q});
            end
            OP_POP:  sp_q <= sp_q + W'(2);
            OP_RET: begin
              pc_q <= rdata_i[W-1:0];
              sp_q <= sp_q + W'(2);
            end
            default: ;
          endcase
          state_q <= S_OP;
        end
        default: state_q <= S_STOP;
      endcase
    end
  end

  assign pc_o      = pc_q;
  assign sp_o      = sp_q;
  assign halted_o  = (state_q == S_STOP);
  assign illegal_o = ill_q;
endmodule

// File: rtl/stk_core.sv
module stk_core #(
  parameter int          MEM_AW = 9,
  parameter int          NREG   = 4,
  parameter logic [15:0] SP_RST = 16'h8000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic        ld_we_i,
  input  logic [15:0] ld_addr_i,
  input  logic [7:0]  ld_data_i,
  input  logic [15:0] peek_addr_i,
  output logic [7:0]  peek_data_o,
  input  logic [1:0]  reg_sel_i,
  output logic [15:0] reg_data_o,
  output logic [15:0] pc_o,
  output logic [15:0] sp_o,
  output logic        halted_o,
  output logic        illegal_o
);
  localparam int W  = 16;
  localparam int SW = $clog2(NREG);

  logic [W-1:0]  raddr, rdata16, core_wa, reg_rd, reg_wd;
  logic [15:0]   core_wd, rdata;
  logic [SW-1:0] reg_sel;
  logic          reg_we, core_we;
  logic          m_we_lo, m_we_hi;
  logic [W-1:0]  m_wa;
  logic [15:0]   m_wd;

  // preload port wins over the core
  assign m_we_lo = ld_we_i | core_we;
  assign m_we_hi = ~ld_we_i & core_we;
  assign m_wa    = ld_we_i ? ld_addr_i : core_wa;
  assign m_wd    = ld_we_i ? {8'h00, ld_data_i} : core_wd;
  assign rdata16 = rdata;

  stk_mem #(.W(W), .AW(MEM_AW)) u_mem (
    .clk_i   (clk_i),
    .we_lo_i (m_we_lo),
    .we_hi_i (m_we_hi),
    .wa_i    (m_wa),
    .wd_i    (m_wd),
    .ra_i    (raddr),
    .rd_o    (rdata),
    .pa_i    (peek_addr_i),
    .pd_o    (peek_data_o)
  );

  stk_regfile #(.NREG(NREG), .W(W)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we),
    .wsel_i   (reg_sel),
    .wd_i     (reg_wd),
    .rsel_a_i (reg_sel),
    .rd_a_o   (reg_rd),
    .rsel_b_i (SW'(reg_sel_i)),
    .rd_b_o   (reg_data_o)
  );

  stk_ctrl #(.W(W), .SW(SW), .SP_RST(SP_RST)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .rdata_i   (rdata16),
    .raddr_o   (raddr),
    .reg_rd_i  (reg_rd),
    .reg_sel_o (reg_sel),
    .reg_we_o  (reg_we),
    .reg_wd_o  (reg_wd),
    .mem_we_o  (core_we),
    .mem_wa_o  (core_wa),
    .mem_wd_o  (core_wd),
    .pc_o      (pc_o),
    .sp_o      (sp_o),
    .halted_o  (halted_o),
    .illegal_o (illegal_o)
  );
endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        run_i,
  input logic [15:0] pc_o,
  input logic [15:0] sp_o,
  input logic        halted_o,
  input logic        illegal_o
);
  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(pc_o)) else $error("halt freeze"); // R8

  AST_ILL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o) else $error("illegal sticky"); // R9

  AST_ILL_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> halted_o) else $error("illegal not halted"); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(pc_o) && $stable(sp_o)) else $error("idle hold"); // R10

  AST_SP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sp_o) |-> (sp_o == $past(sp_o) + 16'd2 || sp_o == $past(sp_o) - 16'd2))
    else $error("sp step"); // R12
endmodule

bind stk_core stk_core_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (run_i),
  .pc_o      (pc_o),
  .sp_o      (sp_o),
  .halted_o  (halted_o),
  .illegal_o (illegal_o)
);

// File: tb/stk_core_bench.sv
module stk_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MSZ = 512;

  logic        clk = 1'b0, rst_ni = 1'b0, run_i = 1'b0, ld_we_i = 1'b0;
  logic [15:0] ld_addr_i = '0, peek_addr_i = '0;
  logic [7:0]  ld_data_i = '0, peek_data_o;
  logic [1:0]  reg_sel_i = '0;
  logic [15:0] reg_data_o, pc_o, sp_o;
  logic        halted_o, illegal_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_core u_stk_core (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i), .ld_we_i(ld_we_i),
    .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i), .peek_addr_i(peek_addr_i),
    .peek_data_o(peek_data_o), .reg_sel_i(reg_sel_i), .reg_data_o(reg_data_o),
    .pc_o(pc_o), .sp_o(sp_o), .halted_o(halted_o), .illegal_o(illegal_o)
  );

  logic [7:0]  mm [MSZ];
  logic [15:0] mr [4];
  logic [15:0] mpc, msp;
  logic        mill;
  logic [7:0]  pg [64];
  int          plen;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mw(input logic [15:0] a);
    return {mm[9'(a + 16'd1)], mm[9'(a)]};
  endfunction

  // bench instruction model
  task automatic model_run();
    logic [7:0] op, b1, b2;
    for (int i = 0; i < 1000; i++) begin
      op = mm[9'(mpc)]; b1 = mm[9'(mpc + 16'd1)]; b2 = mm[9'(mpc + 16'd2)];
      if (op == 8'h05) return;
      if (op < 8'h01 || op > 8'h07) begin mill = 1'b1; return; end
      case (op)
        8'h01: begin mr[b1[1:0]] = {8'h00, b2}; mpc += 16'd3; end
        8'h02: begin msp -= 16'd2; mm[9'(msp)] = mr[b1[1:0]][7:0];
                     mm[9'(msp + 16'd1)] = mr[b1[1:0]][15:8]; mpc += 16'd2; end
        8'h03: begin msp -= 16'd2; mpc += 16'd3; mm[9'(msp)] = mpc[7:0];
                     mm[9'(msp + 16'd1)] = mpc[15:8]; mpc = {b2, b1}; end
        8'h04: begin mr[b1[1:0]] = mw(msp); msp += 16'd2; mpc += 16'd2; end
        8'h06: begin mr[b1[1:0]] = mw(msp + {8'h00, b2}); mpc += 16'd3; end
        default: begin mpc = mw(msp); msp += 16'd2; end
      endcase
    end
  endtask

  task automatic load_and_reset();
    @(negedge clk);
    rst_ni = 1'b0; run_i = 1'b0;
    for (int a = 0; a < MSZ; a++) begin
      ld_we_i = 1'b1; ld_addr_i = 16'(a); ld_data_i = (a < plen) ? pg[a] : 8'h00;
      mm[a] = ld_data_i;
      @(negedge clk);
    end
    ld_we_i = 1'b0;
    for (int r = 0; r < 4; r++) mr[r] = '0;
    mpc = '0; msp = 16'h8000; mill = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_until_halt();
    run_i = 1'b1;
    for (int c = 0; c < 2000 && !halted_o; c++) @(negedge clk);
    #1;
  endtask

  task automatic compare_all(input string tag);
    model_run();
    chk({tag, " R2 R6 R8 pc"}, pc_o, mpc);
    chk({tag, " R3 R4 R12 sp"}, sp_o, msp);
    chk({tag, " R9 illegal"}, illegal_o, mill);
    for (int r = 0; r < 4; r++) begin
      reg_sel_i = 2'(r); #1;
      chk({tag, " R2 R4 R7 reg"}, reg_data_o, mr[r]);
    end
    begin
      int bad = 0;
      for (int a = 9'h1D0; a < MSZ; a++) begin
        peek_addr_i = 16'(a); #1;
        if (peek_data_o !== mm[a]) bad++;
      end
      chk({tag, " R3 R5 stack bytes"}, bad, 0);
    end
  endtask

  task automatic gen_random();
    int depth = 0, n;
    plen = 0;
    n = 4 + ($urandom % 9);
    for (int i = 0; i < n; i++) begin
      int k = $urandom % 4;
      if (depth == 0 && k >= 2) k = k - 2;
      if (depth >= 8 && k == 1) k = 2;
      case (k)
        0: begin pg[plen] = 8'h01; pg[plen+1] = 8'($urandom % 4);
                 pg[plen+2] = 8'($urandom); plen += 3; end
        1: begin pg[plen] = 8'h02; pg[plen+1] = 8'($urandom % 4); plen += 2; depth++; end
        2: begin pg[plen] = 8'h04; pg[plen+1] = 8'($urandom % 4); plen += 2; depth--; end
        default: begin pg[plen] = 8'h06; pg[plen+1] = 8'($urandom % 4);
                 pg[plen+2] = 8'(2 * ($urandom % depth)); plen += 3; end
      endcase
    end
    pg[plen] = 8'h05; plen++;
  endtask

  task automatic set_prog(input logic [7:0] b [], input int n);
    plen = n;
    for (int i = 0; i < n; i++) pg[i] = b[i];
  endtask

  initial begin
    logic [7:0] p [];
    logic [15:0] hold_pc;
    void'($urandom(32'd20240611));

    // R1 reset state and R10 hold
    p = '{8'h01, 8'h00, 8'h07, 8'h05};
    set_prog(p, 4);
    load_and_reset();
    #1;
    chk("R1 pc", pc_o, 16'h0000);
    chk("R1 sp", sp_o, 16'h8000);
    chk("R1 halted", halted_o, 1'b0);
    chk("R1 illegal", illegal_o, 1'b0);
    reg_sel_i = 2'd0; #1;
    chk("R1 r0", reg_data_o, 16'h0000);
    repeat (10) @(negedge clk);
    #1;
    chk("R10 pc held", pc_o, 16'h0000);
    reg_sel_i = 2'd0; #1;
    chk("R10 r0 held", reg_data_o, 16'h0000);
    peek_addr_i = 16'h0002; #1;
    chk("R10 preload byte", peek_data_o, 8'h07);

    // directed call/return with stack parameter
    p = '{8'h01, 8'h00, 8'h07, 8'h02, 8'h00, 8'h03, 8'h0b, 8'h00, 8'h04, 8'h00,
          8'h05, 8'h06, 8'h01, 8'h02, 8'h07};
    set_prog(p, 15);
    load_and_reset();
    run_until_halt();
    chk("R8 halt pc", pc_o, 16'h000a);
    chk("R6 sp restored", sp_o, 16'h8000);
    reg_sel_i = 2'd1; #1;
    chk("R7 stack param", reg_data_o, 16'h0007);
    peek_addr_i = 16'h7ffc; #1;
    chk("R5 return addr lo", peek_data_o, 8'h08);
    peek_addr_i = 16'h01fc; #1;
    chk("R11 alias", peek_data_o, 8'h08);
    compare_all("directed");
    hold_pc = pc_o;
    repeat (20) @(negedge clk);
    #1;
    chk("R8 pc frozen", pc_o, hold_pc);
    chk("R8 still halted", halted_o, 1'b1);

    // R3 byte order of a wide value after pop into another register
    p = '{8'h01, 8'h03, 8'hA5, 8'h02, 8'h03, 8'h04, 8'h02, 8'h05};
    set_prog(p, 8);
    load_and_reset();
    run_until_halt();
    peek_addr_i = 16'h7ffe; #1;
    chk("R3 low byte at sp", peek_data_o, 8'hA5);
    peek_addr_i = 16'h7fff; #1;
    chk("R3 high byte", peek_data_o, 8'h00);
    reg_sel_i = 2'd2; #1;
    chk("R4 popped", reg_data_o, 16'h00A5);
    chk("R12 sp", sp_o, 16'h8000);

    // R9 undefined opcode
    p = '{8'h01, 8'h02, 8'h55, 8'h09, 8'h05};
    set_prog(p, 5);
    load_and_reset();
    run_until_halt();
    chk("R9 pc at bad op", pc_o, 16'h0003);
    chk("R9 illegal set", illegal_o, 1'b1);
    repeat (5) @(negedge clk);
    #1;
    chk("R9 illegal sticky", illegal_o, 1'b1);
    reg_sel_i = 2'd2; #1;
    chk("R2 r2 loaded", reg_data_o, 16'h0055);

    // constrained random programs
    for (int t = 0; t < 20; t++) begin
      gen_random();
      load_and_reset();
      run_until_halt();
      compare_all("random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule